// File: doc/BRIEF.md
# Home Computer Memory Bank Mapper

This block turns one 8-bit bank-control value into the memory map seen by an 8-bit CPU with a 64 KB address space. The space is split into a 32 KB lower window (0x0000–0x7FFF) and two 16 KB upper windows (0x8000–0xBFFF and 0xC000–0xFFFF). A 2 KB overlay for a video card's RAM can also cover 0xF000–0xF7FF. Each window is routed to one source: the boot ROM, the cartridge ROM, the internal RAM, one of two expansion RAM pages, or nothing. A window with no source reads 0xFF and ignores writes.

The mapper produces a chip select, a physical address and, where allowed, a write enable for each memory. It also steers the read data of the selected memory back to the CPU. The mapping depends on the installed RAM size, which is fixed by a parameter. While the cartridge owns the lower window, the block also drops the CPU interrupt and signals that the external I/O port must be ignored. There is no data stream at the edge. Every pin is a plain control or data signal with no handshake. Register writes take effect at the next clock edge. The address decode and the read-data mux are combinational.

Top module: `bank_mapper`

## Requirements
- R1: Lower window, decided by control bits in priority order. bit0=0 selects the cartridge ROM at cartridge offset 0. Otherwise bit1=0 selects expansion page A. Otherwise bit3=0 selects expansion page B. Otherwise the boot ROM is selected at offset 0.
- R2: Upper 32 KB, decided in priority order. bit2=0 selects page A. Otherwise bit4=0 selects page B. Otherwise internal RAM is selected, at RAM address 0 for 0x8000 and 0x4000 for 0xC000.
- R3: The control register resets to 0xFF and the video enable resets to 0. A write to either changes the map only from the clock edge that captures it.
- R4: When bit0=0 and control bits 7:6 are not both 1, the upper windows come from the cartridge or are empty. 0x8000–0xBFFF maps to cartridge offset 0x0000 when bit6=0. 0xC000–0xFFFF maps to cartridge offset 0x4000 when bit7=0. Otherwise the window is empty.
- R5: Page A in the lower window needs RAM_KB ≥ 64. Page A in the upper windows needs RAM_KB > 64. Page B needs RAM_KB > 128. Without the needed size the window is empty.
- R6: With RAM_KB = 16, internal RAM maps only 0xC000–0xFFFF, at RAM address 0, and 0x8000–0xBFFF is empty.
- R7: Page A starts 64 KB below the top of RAM and page B starts 128 KB below it. The lower window uses offset 0 of the page. The upper windows use offsets 32 KB and 48 KB of the page.
- R8: Writes to boot ROM, cartridge or empty windows raise no write enable. RAM and video-RAM windows raise their write enable exactly when cpu_wr is high.
- R9: With the video card present and its enable set, 0xF000–0xF7FF selects video RAM at addr[10:0] and is writable. In the same state 0xF800–0xFFFF is empty.
- R10: While bit0=0, irq_out is held low and ext_io_en is low. Otherwise ext_io_en is high and irq_out follows irq_in.
- R11: At most one chip select is active. cpu_rdata is the selected memory's read data, or 0xFF when no memory is selected.
- R12: The video enable is bit0 of the data written with vid_wr. It has no effect when VIDEO_PRESENT is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_wr | input | 1 | Load bank_wdata into the control register |
| bank_wdata | input | 8 | New control value |
| vid_wr | input | 1 | Load the video enable |
| vid_wdata | input | 8 | Video register data, bit0 is the enable |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe |
| irq_in | input | 1 | Interrupt request from the serial device |
| boot_rdata | input | 8 | Boot ROM read data |
| cart_rdata | input | 8 | Cartridge ROM read data |
| ram_rdata | input | 8 | RAM read data |
| vram_rdata | input | 8 | Video RAM read data |
| boot_cs | output | 1 | Boot ROM select |
| boot_addr | output | 15 | Boot ROM address |
| cart_cs | output | 1 | Cartridge select |
| cart_addr | output | 15 | Cartridge address |
| ram_cs | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | RAM_AW | RAM address, RAM_AW = log2(RAM_KB*1024) |
| vram_cs | output | 1 | Video RAM select |
| vram_we | output | 1 | Video RAM write enable |
| vram_addr | output | 11 | Video RAM address |
| cpu_rdata | output | 8 | Read data to the CPU |
| irq_out | output | 1 | Gated interrupt to the CPU |
| ext_io_en | output | 1 | External I/O port enabled |

## Verification
A wrong control or enable bit shows at the ports on the first access after the clock edge that loaded it. The symptoms are a wrong chip select, a physical address off by a page or slice, a write enable on a ROM window, or ext_io_en and irq_out flipping with the wrong bit. The decode is combinational, so a wrong size threshold or page base shows in the same cycle as the access that touches it. Every one of the 256 control values is probed in each window, with the overlay off and on, against four RAM sizes at once. This way each threshold and override is hit on both of its sides.

// File: rtl/bank_map_pkg.sv
`timescale 1ns/1ps
package bank_map_pkg;
  localparam int PHYS_W = 24;
  localparam int SLICE_BYTES = 16384;
  localparam int PAGE_BYTES = 65536;

  // control bit positions (active low selections)
  localparam int B_LO_CART_N = 0;
  localparam int B_LO_PGA_N  = 1;
  localparam int B_HI_PGA_N  = 2;
  localparam int B_LO_PGB_N  = 3;
  localparam int B_HI_PGB_N  = 4;
  localparam int B_CART_HI_N = 6;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_BOOT = 3'd1,
    SRC_CART = 3'd2,
    SRC_RAM  = 3'd3,
    SRC_VRAM = 3'd4
  } src_e;

  typedef struct packed {
    src_e              src;
    logic              wr_ok;
    logic [PHYS_W-1:0] base;
  } win_cfg_t;

  function automatic win_cfg_t mk_win(input src_e s, input logic w, input int b);
    win_cfg_t c;
    c.src   = s;
    c.wr_ok = w;
    c.base  = PHYS_W'(b);
    return c;
  endfunction
endpackage

// File: rtl/bank_ctrl_regs.sv
`timescale 1ns/1ps
module bank_ctrl_regs #(
  parameter bit VIDEO_PRESENT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bank_wr,
  input  logic [7:0] bank_wdata,
  input  logic       vid_wr,
  input  logic       vid_bit,
  output logic [7:0] ctl_q,
  output logic       vid_en
);
  always_ff @(posedge clk) begin
    if (!rst_n)       ctl_q <= 8'hFF;
    else if (bank_wr) ctl_q <= bank_wdata;
  end

  if (VIDEO_PRESENT) begin : g_vid
    logic en_q;
    always_ff @(posedge clk) begin
      if (!rst_n)      en_q <= 1'b0;
      else if (vid_wr) en_q <= vid_bit;
    end
    assign vid_en = en_q;
  end else begin : g_novid
    logic unused_vid;
    assign unused_vid = vid_wr ^ vid_bit;
    assign vid_en = 1'b0;
  end
endmodule

// File: rtl/bank_window_decode.sv
`timescale 1ns/1ps
module bank_window_decode
  import bank_map_pkg::*;
#(
  parameter int RAM_KB = 64
) (
  input  logic [7:0]       ctl,
  output win_cfg_t         low_cfg,
  output win_cfg_t [1:0]   hi_cfg,
  output logic             cart_mode
);
  localparam int RAM_BYTES = RAM_KB * 1024;
  localparam bit PGA_LO_OK = RAM_KB >= 64;
  localparam bit PGA_HI_OK = RAM_KB > 64;
  localparam bit PGB_OK    = RAM_KB > 128;
  localparam int PGA_BASE  = PGA_LO_OK ? RAM_BYTES - PAGE_BYTES : 0;
  localparam int PGB_BASE  = PGB_OK ? RAM_BYTES - 2 * PAGE_BYTES : 0;
  localparam bit SMALL_INT = RAM_KB == 16;

  logic cart_split;

  assign cart_mode  = !ctl[B_LO_CART_N];
  assign cart_split = cart_mode && (ctl[7:6] != 2'b11);

  always_comb begin
    if (!ctl[B_LO_CART_N])
      low_cfg = mk_win(SRC_CART, 1'b0, 0);
    else if (!ctl[B_LO_PGA_N])
      low_cfg = PGA_LO_OK ? mk_win(SRC_RAM, 1'b1, PGA_BASE) : mk_win(SRC_NONE, 1'b0, 0);
    else if (!ctl[B_LO_PGB_N])
      low_cfg = PGB_OK ? mk_win(SRC_RAM, 1'b1, PGB_BASE) : mk_win(SRC_NONE, 1'b0, 0);
    else
      low_cfg = mk_win(SRC_BOOT, 1'b0, 0);
  end

  for (genvar w = 0; w < 2; w++) begin : g_hi
    localparam int SLICE    = w * SLICE_BYTES;
    localparam int EXP_OFF  = 2 * SLICE_BYTES + SLICE;
    localparam bit INT_OK   = !SMALL_INT || (w == 1);
    localparam int INT_BASE = SMALL_INT ? 0 : SLICE;
    win_cfg_t cfg_w;

    always_comb begin
      if (cart_split)
        cfg_w = ctl[B_CART_HI_N + w] ? mk_win(SRC_NONE, 1'b0, 0)
                                     : mk_win(SRC_CART, 1'b0, SLICE);
      else if (!ctl[B_HI_PGA_N])
        cfg_w = PGA_HI_OK ? mk_win(SRC_RAM, 1'b1, PGA_BASE + EXP_OFF)
                          : mk_win(SRC_NONE, 1'b0, 0);
      else if (!ctl[B_HI_PGB_N])
        cfg_w = PGB_OK ? mk_win(SRC_RAM, 1'b1, PGB_BASE + EXP_OFF)
                       : mk_win(SRC_NONE, 1'b0, 0);
      else
        cfg_w = INT_OK ? mk_win(SRC_RAM, 1'b1, INT_BASE)
                       : mk_win(SRC_NONE, 1'b0, 0);
    end

    assign hi_cfg[w] = cfg_w;
  end

  logic unused_ctl;
  assign unused_ctl = ctl[5];
endmodule

// File: rtl/bank_addr_route.sv
`timescale 1ns/1ps
module bank_addr_route
  import bank_map_pkg::*;
#(
  parameter int RAM_AW = 16
) (
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_wr,
  input  win_cfg_t          low_cfg,
  input  win_cfg_t [1:0]    hi_cfg,
  input  logic              vid_en,
  input  logic [7:0]        boot_rdata,
  input  logic [7:0]        cart_rdata,
  input  logic [7:0]        ram_rdata,
  input  logic [7:0]        vram_rdata,
  output logic              boot_cs,
  output logic [14:0]       boot_addr,
  output logic              cart_cs,
  output logic [14:0]       cart_addr,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              vram_cs,
  output logic              vram_we,
  output logic [10:0]       vram_addr,
  output logic [7:0]        cpu_rdata
);
  win_cfg_t          sel;
  logic [PHYS_W-1:0] offs;
  logic [PHYS_W-1:0] phys;
  logic              in_ovl;

  always_comb begin
    in_ovl = vid_en && (cpu_addr[15:12] == 4'hF);
    if (in_ovl)
      sel = cpu_addr[11] ? mk_win(SRC_NONE, 1'b0, 0) : mk_win(SRC_VRAM, 1'b1, 0);
    else if (!cpu_addr[15])
      sel = low_cfg;
    else
      sel = hi_cfg[cpu_addr[14]];

    if (in_ovl)           offs = {{(PHYS_W-11){1'b0}}, cpu_addr[10:0]};
    else if (cpu_addr[15]) offs = {{(PHYS_W-14){1'b0}}, cpu_addr[13:0]};
    else                  offs = {{(PHYS_W-15){1'b0}}, cpu_addr[14:0]};
    phys = sel.base + offs;
  end

  assign boot_cs = sel.src == SRC_BOOT;
  assign cart_cs = sel.src == SRC_CART;
  assign ram_cs  = sel.src == SRC_RAM;
  assign vram_cs = sel.src == SRC_VRAM;
  assign ram_we  = ram_cs && sel.wr_ok && cpu_wr;
  assign vram_we = vram_cs && sel.wr_ok && cpu_wr;

  assign boot_addr = phys[14:0];
  assign cart_addr = phys[14:0];
  assign ram_addr  = phys[RAM_AW-1:0];
  assign vram_addr = phys[10:0];

  always_comb begin
    case (sel.src)
      SRC_BOOT: cpu_rdata = boot_rdata;
      SRC_CART: cpu_rdata = cart_rdata;
      SRC_RAM:  cpu_rdata = ram_rdata;
      SRC_VRAM: cpu_rdata = vram_rdata;
      default:  cpu_rdata = 8'hFF;
    endcase
  end

  logic unused_phys;
  assign unused_phys = ^phys[PHYS_W-1:RAM_AW];
endmodule

// File: rtl/bank_mapper.sv
`timescale 1ns/1ps
module bank_mapper
  import bank_map_pkg::*;
#(
  parameter int RAM_KB        = 64,
  parameter bit VIDEO_PRESENT = 1'b1,
  localparam int RAM_AW       = $clog2(RAM_KB * 1024)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_wr,
  input  logic [7:0]        bank_wdata,
  input  logic              vid_wr,
  input  logic [7:0]        vid_wdata,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_wr,
  input  logic              irq_in,
  input  logic [7:0]        boot_rdata,
  input  logic [7:0]        cart_rdata,
  input  logic [7:0]        ram_rdata,
  input  logic [7:0]        vram_rdata,
  output logic              boot_cs,
  output logic [14:0]       boot_addr,
  output logic              cart_cs,
  output logic [14:0]       cart_addr,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              vram_cs,
  output logic              vram_we,
  output logic [10:0]       vram_addr,
  output logic [7:0]        cpu_rdata,
  output logic              irq_out,
  output logic              ext_io_en
);
  logic [7:0]     ctl_q;
  logic           vid_en;
  win_cfg_t       low_cfg;
  win_cfg_t [1:0] hi_cfg;
  logic           cart_mode;

  bank_ctrl_regs #(.VIDEO_PRESENT(VIDEO_PRESENT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_wr   (bank_wr),
    .bank_wdata(bank_wdata),
    .vid_wr    (vid_wr),
    .vid_bit   (vid_wdata[0]),
    .ctl_q     (ctl_q),
    .vid_en    (vid_en)
  );

  bank_window_decode #(.RAM_KB(RAM_KB)) u_decode (
    .ctl      (ctl_q),
    .low_cfg  (low_cfg),
    .hi_cfg   (hi_cfg),
    .cart_mode(cart_mode)
  );

  bank_addr_route #(.RAM_AW(RAM_AW)) u_route (
    .cpu_addr  (cpu_addr),
    .cpu_wr    (cpu_wr),
    .low_cfg   (low_cfg),
    .hi_cfg    (hi_cfg),
    .vid_en    (vid_en),
    .boot_rdata(boot_rdata),
    .cart_rdata(cart_rdata),
    .ram_rdata (ram_rdata),
    .vram_rdata(vram_rdata),
    .boot_cs   (boot_cs),
    .boot_addr (boot_addr),
    .cart_cs   (cart_cs),
    .cart_addr (cart_addr),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .vram_cs   (vram_cs),
    .vram_we   (vram_we),
    .vram_addr (vram_addr),
    .cpu_rdata (cpu_rdata)
  );

  assign ext_io_en = !cart_mode;
  assign irq_out   = irq_in && !cart_mode;

  logic unused_vid;
  assign unused_vid = ^vid_wdata[7:1];
endmodule

// File: rtl/bank_mapper_chk.sv
`timescale 1ns/1ps
module bank_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bank_wr,
  input logic [7:0]  bank_wdata,
  input logic [15:0] cpu_addr,
  input logic        cpu_wr,
  input logic        irq_in,
  input logic        boot_cs,
  input logic        cart_cs,
  input logic        ram_cs,
  input logic        ram_we,
  input logic        vram_cs,
  input logic        vram_we,
  input logic [7:0]  cpu_rdata,
  input logic        irq_out,
  input logic        ext_io_en
);
  // R8
  rom_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_cs || cart_cs) |-> !(ram_we || vram_we));

  // R8
  we_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || vram_we) |-> cpu_wr);

  // R11
  one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({boot_cs, cart_cs, ram_cs, vram_cs}));

  // R11
  empty_reads_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(boot_cs || cart_cs || ram_cs || vram_cs) |-> cpu_rdata == 8'hFF);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_io_en |-> !irq_out);

  // R10
  irq_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_io_en && irq_in) |-> irq_out);

  // R3
  cart_enter_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr && !bank_wdata[0]) |=> !ext_io_en);

  // R3
  cart_leave_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr && bank_wdata[0]) |=> ext_io_en);

  // R9
  vram_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vram_cs |-> cpu_addr[15:11] == 5'b11110);
endmodule

bind bank_mapper bank_mapper_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bank_wr   (bank_wr),
  .bank_wdata(bank_wdata),
  .cpu_addr  (cpu_addr),
  .cpu_wr    (cpu_wr),
  .irq_in    (irq_in),
  .boot_cs   (boot_cs),
  .cart_cs   (cart_cs),
  .ram_cs    (ram_cs),
  .ram_we    (ram_we),
  .vram_cs   (vram_cs),
  .vram_we   (vram_we),
  .cpu_rdata (cpu_rdata),
  .irq_out   (irq_out),
  .ext_io_en (ext_io_en)
);

// File: tb/bank_mapper_tb.sv
`timescale 1ns/1ps
module bank_mapper_tb;
  typedef struct packed {
    logic [2:0]  sel;   // 0 none, 1 boot, 2 cart, 3 ram, 4 vram
    logic [23:0] phys;
    logic        we;
    logic [7:0]  rd;
    logic        irq;
    logic        io;
    logic [3:0]  tag;
  } exp_t;
  typedef exp_t [3:0] exp4_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_wr = 1'b0;
  logic [7:0]  bank_wdata = 8'h00;
  logic        vid_wr = 1'b0;
  logic [7:0]  vid_wdata = 8'h00;
  logic [15:0] cpu_addr = 16'h0000;
  logic        cpu_wr = 1'b0;
  logic        irq_in = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp4_t q[$];
  exp_t act [4];

  logic [7:0] cur_v = 8'hFF;
  logic       cur_vid = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(input logic [2:0] s, input logic [23:0] p);
    return p[7:0] ^ p[15:8] ^ {p[17:16], 3'b000, s};
  endfunction

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd9: return "R9";   4'd12: return "R12";
      default: return "R?";
    endcase
  endfunction

  function automatic exp_t pack_act(input logic b, c, r, v, we, input logic [14:0] ba, ca,
                                    input logic [23:0] ra, input logic [10:0] va,
                                    input logic [7:0] rd, input logic irq, io);
    exp_t e;
    e = '0;
    e.sel  = b ? 3'd1 : c ? 3'd2 : r ? 3'd3 : v ? 3'd4 : 3'd0;
    e.phys = b ? 24'(ba) : c ? 24'(ca) : r ? ra : v ? 24'(va) : 24'd0;
    e.we = we; e.rd = rd; e.irq = irq; e.io = io;
    return e;
  endfunction

  // reference model, written from the requirements
  function automatic exp_t ref_map(input int kb, input logic [7:0] v, input logic vid,
                                   input logic [15:0] a, input logic wr, input logic irq);
    exp_t e;
    int top;
    int half;
    top = kb * 1024;
    e = '0;
    if (vid && a >= 16'hF000) begin                       // R9
      e.tag = 4'd9;
      if (a < 16'hF800) begin e.sel = 3'd4; e.phys = 24'(a - 16'hF000); end
    end else if (a < 16'h8000) begin                      // R1
      e.tag = 4'd1;
      if (!v[0]) begin e.sel = 3'd2; e.phys = 24'(a); end
      else if (!v[1]) begin
        if (kb >= 64) begin e.sel = 3'd3; e.phys = 24'(top - 65536 + int'(a)); e.tag = 4'd7; end
        else e.tag = 4'd5;
      end else if (!v[3]) begin
        if (kb > 128) begin e.sel = 3'd3; e.phys = 24'(top - 131072 + int'(a)); e.tag = 4'd7; end
        else e.tag = 4'd5;
      end else begin e.sel = 3'd1; e.phys = 24'(a); end
    end else if (!v[0] && v[7:6] != 2'b11) begin          // R4
      e.tag = 4'd4;
      half = a[14] ? 1 : 0;
      if (!v[6 + half]) begin e.sel = 3'd2; e.phys = 24'(half * 16384 + int'(a[13:0])); end
    end else begin                                        // R2
      e.tag = 4'd2;
      if (!v[2]) begin
        if (kb > 64) begin e.sel = 3'd3; e.phys = 24'(top - 65536 + 32768 + int'(a) - 32768); e.tag = 4'd7; end
        else e.tag = 4'd5;
      end else if (!v[4]) begin
        if (kb > 128) begin e.sel = 3'd3; e.phys = 24'(top - 131072 + int'(a) - 32768 + 32768); e.tag = 4'd7; end
        else e.tag = 4'd5;
      end else if (kb == 16) begin                        // R6
        e.tag = 4'd6;
        if (a >= 16'hC000) begin e.sel = 3'd3; e.phys = 24'(a - 16'hC000); end
      end else begin e.sel = 3'd3; e.phys = 24'(a - 16'h8000); end
    end
    e.we  = wr && (e.sel == 3'd3 || e.sel == 3'd4);
    e.rd  = (e.sel == 3'd0) ? 8'hFF : pat(e.sel, e.phys);
    e.io  = v[0];
    e.irq = irq && v[0];
    return e;
  endfunction

  for (genvar i = 0; i < 4; i++) begin : g_sz
    localparam int KB = (i == 0) ? 16 : (16 << (i + 1));
    localparam int RA = $clog2(KB * 1024);
    logic bcs, ccs, rcs, rwe, vcs, vwe, irqo, ioen;
    logic [14:0] ba, ca;
    logic [RA-1:0] ra;
    logic [10:0] va;
    logic [7:0] rd;

    bank_mapper #(.RAM_KB(KB), .VIDEO_PRESENT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .bank_wr(bank_wr), .bank_wdata(bank_wdata),
      .vid_wr(vid_wr), .vid_wdata(vid_wdata), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
      .irq_in(irq_in),
      .boot_rdata(pat(3'd1, 24'(ba))), .cart_rdata(pat(3'd2, 24'(ca))),
      .ram_rdata(pat(3'd3, 24'(ra))), .vram_rdata(pat(3'd4, 24'(va))),
      .boot_cs(bcs), .boot_addr(ba), .cart_cs(ccs), .cart_addr(ca),
      .ram_cs(rcs), .ram_we(rwe), .ram_addr(ra), .vram_cs(vcs), .vram_we(vwe),
      .vram_addr(va), .cpu_rdata(rd), .irq_out(irqo), .ext_io_en(ioen)
    );

    assign act[i] = pack_act(bcs, ccs, rcs, vcs, rwe | vwe, ba, ca, 24'(ra), va, rd, irqo, ioen);
  end

  function automatic int kb_of(input int i);
    return (i == 0) ? 16 : (16 << (i + 1));
  endfunction

  // driver: apply one access and push what each size must show
  task automatic probe(input logic [15:0] a, input logic wr, input logic [3:0] tag_ovr);
    exp4_t item;
    cpu_addr = a;
    cpu_wr = wr;
    irq_in = a[0] ^ cur_v[1] ^ 1'b1;
    for (int i = 0; i < 4; i++) begin
      item[i] = ref_map(kb_of(i), cur_v, cur_vid, a, wr, irq_in);
      if (tag_ovr != 4'd0) item[i].tag = tag_ovr;
    end
    q.push_back(item);
    @(posedge clk);
    #1;
  endtask

  // R3: the new value is not visible before the capturing edge
  task automatic write_bank(input logic [7:0] v);
    bank_wr = 1'b1;
    bank_wdata = v;
    probe(16'h1234, 1'b0, 4'd3);
    bank_wr = 1'b0;
    cur_v = v;
  endtask

  // R12
  task automatic write_vid(input logic b);
    vid_wr = 1'b1;
    vid_wdata = {7'h55, b};
    probe(16'hF100, 1'b1, 4'd12);
    vid_wr = 1'b0;
    cur_vid = b;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp4_t e;
        e = q.pop_front();
        for (int i = 0; i < 4; i++) begin
          checks += 4;
          if (act[i].sel != e[i].sel || (e[i].sel != 3'd0 && act[i].phys != e[i].phys)) begin
            errors++;
            $display("FAIL %s kb=%0d addr=%h ctl=%h: sel/phys actual %0d/%h expected %0d/%h",
                     tag_name(e[i].tag), kb_of(i), cpu_addr, cur_v, act[i].sel, act[i].phys,
                     e[i].sel, e[i].phys);
          end
          if (act[i].we != e[i].we) begin
            errors++;
            $display("FAIL R8 kb=%0d addr=%h: we actual %0b expected %0b",
                     kb_of(i), cpu_addr, act[i].we, e[i].we);
          end
          if (act[i].rd != e[i].rd) begin
            errors++;
            $display("FAIL R11 kb=%0d addr=%h: rdata actual %h expected %h",
                     kb_of(i), cpu_addr, act[i].rd, e[i].rd);
          end
          if (act[i].irq != e[i].irq || act[i].io != e[i].io) begin
            errors++;
            $display("FAIL R10 kb=%0d: irq/io actual %0b/%0b expected %0b/%0b",
                     kb_of(i), act[i].irq, act[i].io, e[i].irq, e[i].io);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R3 reset state: boot low, internal RAM high, no overlay
    probe(16'h0000, 1'b1, 4'd3);
    probe(16'h8000, 1'b1, 4'd3);
    probe(16'hC000, 1'b1, 4'd3);
    probe(16'hF000, 1'b1, 4'd3);
    // R12 enable timing and overlay edges
    write_vid(1'b1);
    probe(16'hF100, 1'b1, 4'd12);
    probe(16'hF7FF, 1'b1, 4'd9);
    probe(16'hF800, 1'b1, 4'd9);
    write_vid(1'b0);
    probe(16'hF100, 1'b1, 4'd12);
    for (int vid = 0; vid < 2; vid++) begin
      write_vid(vid[0]);
      for (int v = 0; v < 256; v++) begin
        write_bank(v[7:0]);
        probe(16'h0000, 1'b1, 4'd0);
        probe(16'h7FFE, 1'b1, 4'd0);
        probe(16'h8ABC, 1'b0, 4'd0);
        probe(16'hBFFF, 1'b1, 4'd0);
        probe(16'hC123, 1'b1, 4'd0);
        probe(16'hF456, 1'b1, 4'd0);
        probe(16'hF9AB, 1'b0, 4'd0);
        probe(16'hFFFF, 1'b1, 4'd0);
      end
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule